// File: doc/BRIEF.md
# Cascaded Pre-Divider Path Control

This block sits in front of a channel divider in a clock distribution path. It takes a fast input clock and either passes it through a small pre-divider that divides by 1 to 6, or routes it around that pre-divider when a source-select bit is set. Odd pre-divide ratios produce a near-50% output because the block uses both clock edges.

The block also looks at the pre-divider setting, the source-select bit and the channel divider's own settings (a bypass flag and a ratio). From these it reports the overall division ratio from the input clock to the channel divider's output. Routing around the pre-divider is not treated as dividing by 1. Selecting the pre-divider at 1 while the channel divider is bypassed is an illegal combination. The block flags it combinationally and holds the forwarded clock low.

The pre-divider core is a small state machine with three states. `ST_HOLD` is idle: the output is low and the counter is cleared. `ST_HIGH` is the high phase, which lasts ceil(D/2) input cycles. `ST_LOW` is the low phase, which lasts floor(D/2) input cycles. Its transitions are:
- T_START: `ST_HOLD` to `ST_HIGH`, when the divider is enabled.
- T_FALL: `ST_HIGH` to `ST_LOW`, when the high-phase count is reached.
- T_RISE: `ST_LOW` to `ST_HIGH`, when the low-phase count is reached.
- T_STOP: any state to `ST_HOLD`, when the enable drops.

The divider is enabled only when the pre-divider path is selected, the configuration is legal and D is at least 2.

Top module: `pre_div_path`

## Requirements
- R1: With `src_bypass`=0, a legal configuration and `pre_ratio` D in 1..6 (binary code equals D), `clk_to_ch` has a period of D input cycles and stays high for D/2 input periods (half a cycle resolution for odd D; D=1 forwards the input clock).
- R2: With `src_bypass`=1 and a legal configuration, `clk_to_ch` follows the input clock (period 1 cycle, high half a cycle), and `pre_ratio` has no effect.
- R3: With `src_bypass`=0, D in 1..6, `ch_bypass`=0 and `ch_ratio` C in 2..32, `total_ratio` equals D*C and `cfg_illegal` is 0.
- R4: With `src_bypass`=0, D in 2..6 and `ch_bypass`=1, `total_ratio` equals D and `cfg_illegal` is 0.
- R5: With `src_bypass`=0, D=1 and `ch_bypass`=1, `cfg_illegal` is 1, `total_ratio` is 0 and `clk_to_ch` is held low.
- R6: With `src_bypass`=1, `total_ratio` equals C when `ch_bypass`=0 and C is in 2..32, and equals 1 when `ch_bypass`=1; `cfg_illegal` is 0 in both cases.
- R7: Out-of-range codes are illegal: `pre_ratio` of 0 or 7 while `src_bypass`=0, or `ch_ratio` outside 2..32 while `ch_bypass`=0. The result is `cfg_illegal`=1, `total_ratio`=0 and `clk_to_ch` held low.
- R8: `cfg_illegal` and `total_ratio` depend only on the configuration inputs, even during reset. While `rst_n` is low, a pre-divided path with D of at least 2 keeps `clk_to_ch` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_ratio | input | 3 | Pre-divide ratio code, value equals ratio (1..6 legal) |
| src_bypass | input | 1 | 1 routes the clock around the pre-divider |
| ch_bypass | input | 1 | Channel divider bypass flag |
| ch_ratio | input | 6 | Channel divider ratio (2..32 legal) |
| clk_to_ch | output | 1 | Clock forwarded to the channel divider |
| total_ratio | output | 8 | Overall division ratio, 0 when illegal |
| cfg_illegal | output | 1 | Illegal configuration flag |

## Verification
The assertions assume that the configuration inputs change only between test points and are then held steady for many cycles. They also assume that the input clock is free-running, so the longest phase of the pre-divider is ceil(6/2) cycles.

The stimulus follows this pattern. It steps through every combination of select bit, every pre-divide code including the out-of-range ones, both channel bypass values and a set of channel ratios covering both bounds and both sides of them. After each change it waits for the divider to settle before measuring the period and the high time.

// File: rtl/pre_div_path_pkg.sv
`timescale 1ns/1ps
package pre_div_path_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_t;

endpackage

// File: rtl/pre_div_cfg.sv
`timescale 1ns/1ps
module pre_div_cfg #(
    parameter int PRE_W   = 3,
    parameter int PRE_MAX = 6,
    parameter int CH_W    = 6,
    parameter int CH_MIN  = 2,
    parameter int CH_MAX  = 32,
    parameter int TOT_W   = 8
) (
    input  logic [PRE_W-1:0] pre_ratio,
    input  logic             src_bypass,
    input  logic             ch_bypass,
    input  logic [CH_W-1:0]  ch_ratio,
    output logic [TOT_W-1:0] total_ratio,
    output logic             cfg_illegal
);

    logic pre_ok;
    logic ch_ok;

    always_comb begin
        pre_ok = (pre_ratio >= PRE_W'(1)) && (pre_ratio <= PRE_W'(PRE_MAX));
        ch_ok  = (ch_ratio >= CH_W'(CH_MIN)) && (ch_ratio <= CH_W'(CH_MAX));
    end

    always_comb begin
        total_ratio = '0;
        cfg_illegal = 1'b0;
        if (src_bypass) begin
            if (ch_bypass) begin
                total_ratio = TOT_W'(1);
            end else if (ch_ok) begin
                total_ratio = TOT_W'(ch_ratio);
            end else begin
                cfg_illegal = 1'b1;
            end
        end else if (!pre_ok) begin
            cfg_illegal = 1'b1;
        end else if (ch_bypass) begin
            if (pre_ratio == PRE_W'(1)) begin
                cfg_illegal = 1'b1;
            end else begin
                total_ratio = TOT_W'(pre_ratio);
            end
        end else if (ch_ok) begin
            total_ratio = TOT_W'(pre_ratio) * TOT_W'(ch_ratio);
        end else begin
            cfg_illegal = 1'b1;
        end
    end

endmodule

// File: rtl/pre_div_fsm.sv
`timescale 1ns/1ps
module pre_div_fsm
    import pre_div_path_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] ratio,
    output logic             pos_q,
    output logic             div_clk
);

    localparam int CNT_W = PRE_W + 1;

    div_state_t       state_q;
    div_state_t       state_n;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_last;
    logic [CNT_W-1:0] lo_last;
    logic             neg_q;

    always_comb begin
        hi_last = ((CNT_W'(ratio) + CNT_W'(1)) >> 1) - CNT_W'(1);
        lo_last = (CNT_W'(ratio) >> 1) - CNT_W'(1);
    end

    // next-state logic: T_START, T_FALL, T_RISE, T_STOP
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HOLD: if (run) state_n = ST_HIGH;
            ST_HIGH: begin
                if (!run)                  state_n = ST_HOLD;
                else if (cnt_q >= hi_last) state_n = ST_LOW;
            end
            ST_LOW: begin
                if (!run)                  state_n = ST_HOLD;
                else if (cnt_q >= lo_last) state_n = ST_HIGH;
            end
            default: state_n = ST_HOLD;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_n != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // half-cycle delayed copy for odd ratios
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
    end

    // outputs
    always_comb begin
        pos_q   = (state_q == ST_HIGH);
        div_clk = ratio[0] ? (pos_q & neg_q) : pos_q;
    end

endmodule

// File: rtl/pre_div_path.sv
`timescale 1ns/1ps
module pre_div_path #(
    parameter int PRE_W   = 3,
    parameter int PRE_MAX = 6,
    parameter int CH_W    = 6,
    parameter int CH_MIN  = 2,
    parameter int CH_MAX  = 32,
    parameter int TOT_W   = $clog2(PRE_MAX * CH_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_ratio,
    input  logic             src_bypass,
    input  logic             ch_bypass,
    input  logic [CH_W-1:0]  ch_ratio,
    output logic             clk_to_ch,
    output logic [TOT_W-1:0] total_ratio,
    output logic             cfg_illegal
);

    logic div_run;
    logic div_pos;
    logic div_clk;
    logic pre_unity;

    pre_div_cfg #(
        .PRE_W(PRE_W), .PRE_MAX(PRE_MAX), .CH_W(CH_W),
        .CH_MIN(CH_MIN), .CH_MAX(CH_MAX), .TOT_W(TOT_W)
    ) u_cfg (
        .pre_ratio  (pre_ratio),
        .src_bypass (src_bypass),
        .ch_bypass  (ch_bypass),
        .ch_ratio   (ch_ratio),
        .total_ratio(total_ratio),
        .cfg_illegal(cfg_illegal)
    );

    always_comb begin
        pre_unity = (pre_ratio == PRE_W'(1));
        div_run   = !src_bypass && !cfg_illegal && !pre_unity;
    end

    pre_div_fsm #(.PRE_W(PRE_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (div_run),
        .ratio  (pre_ratio),
        .pos_q  (div_pos),
        .div_clk(div_clk)
    );

    // source select and static hold
    always_comb begin
        if (cfg_illegal)     clk_to_ch = 1'b0;
        else if (src_bypass) clk_to_ch = clk;
        else if (pre_unity)  clk_to_ch = clk;
        else                 clk_to_ch = div_clk;
    end

endmodule

// File: rtl/pre_div_path_chk.sv
`timescale 1ns/1ps
module pre_div_path_chk #(
    parameter int PRE_MAX = 6,
    parameter int CH_MAX  = 32,
    parameter int TOT_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_bypass,
    input logic             ch_bypass,
    input logic             clk_to_ch,
    input logic [TOT_W-1:0] total_ratio,
    input logic             cfg_illegal,
    input logic             div_run,
    input logic             div_pos
);

    localparam int HALF_MAX = (PRE_MAX + 1) / 2;

    logic       prev_pos;
    logic [3:0] same_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_pos <= 1'b0;
            same_cnt <= '0;
        end else begin
            prev_pos <= div_pos;
            if (!div_run)              same_cnt <= '0;
            else if (div_pos == prev_pos) same_cnt <= same_cnt + 4'd1;
            else                       same_cnt <= '0;
        end
    end

    // R1
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_run |-> (same_cnt <= 4'(HALF_MAX - 1)));

    // R2
    bypass_fwd_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (src_bypass && !cfg_illegal) |-> clk_to_ch);

    // R5
    static_out_chk: assert property (@(negedge clk) disable iff (!rst_n)
        cfg_illegal |-> !clk_to_ch);

    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |-> (total_ratio == '0));

    // R3
    ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_illegal |-> (total_ratio >= TOT_W'(1) && total_ratio <= TOT_W'(PRE_MAX * CH_MAX)));

    // R6
    both_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_bypass && ch_bypass) |-> (total_ratio == TOT_W'(1) && !cfg_illegal));

endmodule

bind pre_div_path pre_div_path_chk #(
    .PRE_MAX(PRE_MAX), .CH_MAX(CH_MAX), .TOT_W(TOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_bypass (src_bypass),
    .ch_bypass  (ch_bypass),
    .clk_to_ch  (clk_to_ch),
    .total_ratio(total_ratio),
    .cfg_illegal(cfg_illegal),
    .div_run    (div_run),
    .div_pos    (div_pos)
);

// File: tb/pre_div_path_tb.sv
`timescale 1ns/1ps
module pre_div_path_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pre_ratio = 3'd3;
    logic       src_bypass = 1'b0;
    logic       ch_bypass = 1'b1;
    logic [5:0] ch_ratio = 6'd2;
    logic       clk_to_ch;
    logic [7:0] total_ratio;
    logic       cfg_illegal;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pre_div_path u_dut (
        .clk(clk), .rst_n(rst_n), .pre_ratio(pre_ratio), .src_bypass(src_bypass),
        .ch_bypass(ch_bypass), .ch_ratio(ch_ratio), .clk_to_ch(clk_to_ch),
        .total_ratio(total_ratio), .cfg_illegal(cfg_illegal)
    );

    function automatic int exp_total(input int sel, input int d, input int chb, input int c);
        bit c_ok = (c >= 2) && (c <= 32);
        if (sel == 1) begin
            if (chb == 1) return 1;
            return c_ok ? c : 0;
        end
        if (d < 1 || d > 6) return 0;
        if (chb == 1) return (d == 1) ? 0 : d;
        return c_ok ? d * c : 0;
    endfunction

    function automatic string ratio_tag(input int sel, input int d, input int chb, input int c);
        if (sel == 1) return ((chb == 0) && (c < 2 || c > 32)) ? "R7" : "R6";
        if (d < 1 || d > 6) return "R7";
        if (chb == 1) return (d == 1) ? "R5" : "R4";
        return (c < 2 || c > 32) ? "R7" : "R3";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_low(input string tag, input int ns);
        int seen = 0;
        for (int i = 0; i < ns; i++) begin
            #1;
            if (clk_to_ch) seen = 1;
        end
        check(tag, seen, 0);
    endtask

    task automatic measure(input string tag, input int d);
        realtime t0, t1, t2;
        @(posedge clk_to_ch); t0 = $realtime;
        @(negedge clk_to_ch); t1 = $realtime;
        @(posedge clk_to_ch); t2 = $realtime;
        check({tag, " period_ns"}, int'(t2 - t0), 4 * d);
        check({tag, " high_ns"}, int'(t1 - t0), 2 * d);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c_set[8] = '{0, 1, 2, 3, 17, 31, 32, 33};
        // R8: held low in reset, flags combinational during reset
        #1;
        check_low("R8 reset_low", 40);
        check("R8 total_in_reset", int'(total_ratio), 3);
        pre_ratio = 3'd1;
        #1;
        check("R8 illegal_in_reset", int'(cfg_illegal), 1);
        check("R8 total_zero_in_reset", int'(total_ratio), 0);
        pre_ratio = 3'd3;
        @(negedge clk);
        rst_n = 1'b1;

        for (int sel = 0; sel < 2; sel++) begin
            for (int d = 0; d < 8; d++) begin
                for (int chb = 0; chb < 2; chb++) begin
                    for (int k = 0; k < 8; k++) begin
                        int c = c_set[k];
                        int e;
                        string tg;
                        @(posedge clk); #1;
                        src_bypass = sel[0];
                        pre_ratio  = 3'(d);
                        ch_bypass  = chb[0];
                        ch_ratio   = 6'(c);
                        e  = exp_total(sel, d, chb, c);
                        tg = ratio_tag(sel, d, chb, c);
                        #1;
                        check({tg, " total"}, int'(total_ratio), e);
                        check({tg, " illegal"}, int'(cfg_illegal), (e == 0) ? 1 : 0);
                        repeat (20) @(posedge clk);
                        #1;
                        if (e == 0) begin
                            check_low({tg, " static_low"}, 60);
                        end else if (sel == 1) begin
                            measure("R2", 1);
                        end else begin
                            measure("R1", d);
                        end
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule